// File: doc/BRIEF.md
# Machine-Cycle Reset Qualifier with Register Initialisation

The block takes a raw, asynchronous reset pin and turns it into a clean internal reset. It divides the oscillator clock into machine cycles of twelve clocks and looks at the pin only once in each cycle, on the tenth clock. A single high reading counts as a glitch and is ignored. The internal reset rises only when the pin has read high on two back-to-back sample points. It falls at the first sample point where the pin reads low. Before sampling, the pin passes through a two-flop synchronizer.

While the internal reset is high, the block forces reset values into a small bank of special function registers:

- The port latches go to all ones.
- The stack pointer goes to 07h.
- The generic registers clear.
- The power control register clears every bit except bit 4.
- The serial data buffer keeps its contents.

Outside reset, each register accepts writes through one shared write port.

Top module: `mc_reset_gate`

## Requirements
- R1: The synchronized pin is sampled once per 12-clock machine cycle. The sample falls on the clock whose cycle counter value is 9, with the counter running 0 to 11. `sys_rst` therefore only ever changes on that clock.
- R2: `sys_rst` rises at a sample point where the pin has read high on two consecutive sample points.
- R3: A high pulse seen by only one sample point never raises `sys_rst`. For example, a pulse held for exactly 12 clocks is ignored, and no register changes because of it.
- R4: `sys_rst` falls at the first sample point that reads the pin low. This is at most 14 clocks after the pin goes low.
- R5: On each clock while `sys_rst` is high, every port latch is loaded with FFh.
- R6: On each clock while `sys_rst` is high, the stack pointer is loaded with 07h.
- R7: On each clock while `sys_rst` is high, the generic registers load 00h, and the power control register loads 00h in every bit except bit 4.
- R8: The serial data buffer keeps its value through reset.
- R9: Bit 4 of the power control register keeps its value through reset.
- R10: The write port updates registers as follows:
  - A write with `wr_en` high stores `wr_data` on the next clock.
  - The address map is: port latches 0 to 3, stack pointer 4, serial buffer 5, power control 6, generic registers 7 to 10.
  - Writes are ignored while `sys_rst` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_pin | input | 1 | Raw external reset pin, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| sys_rst | output | 1 | Qualified internal reset |
| port_q | output | 32 | Port latches, latch n in bits 8n+7:8n |
| sp_q | output | 8 | Stack pointer |
| sbuf_q | output | 8 | Serial data buffer |
| pcon_q | output | 8 | Power control register |
| gen_q | output | 32 | Generic registers, register n in bits 8n+7:8n |

## Verification
A register write and an active reset can land in the same cycle, and reset must win. To provoke this, the bench holds a write strobe to the stack pointer without a break while the pin stays high for three machine cycles. It then checks that the stack pointer reads 07h while both are active. A single-sample pulse is also driven while earlier writes are in place, and all registers are then checked for their written values, which shows the glitch touched nothing.

// File: rtl/mc_reset_gate.sv
module mc_reset_gate #(
  parameter int CLKS_PER_MC  = 12,
  parameter int SAMPLE_SLOT  = 9,
  parameter int HOLD_SAMPLES = 2,
  parameter int NPORTS       = 4,
  parameter int NGEN         = 4,
  parameter int DW           = 8,
  parameter int AW           = 4,
  parameter int SP_INIT      = 7,
  parameter int PCON_KEEP    = 4
) (
  input  logic                 clk,
  input  logic                 rst_pin,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  output logic                 sys_rst,
  output logic [NPORTS*DW-1:0] port_q,
  output logic [DW-1:0]        sp_q,
  output logic [DW-1:0]        sbuf_q,
  output logic [DW-1:0]        pcon_q,
  output logic [NGEN*DW-1:0]   gen_q
);
  localparam int PW = $clog2(CLKS_PER_MC);
  localparam int HW = $clog2(HOLD_SAMPLES + 1);
  localparam int A_SP = NPORTS;
  localparam int A_SBUF = NPORTS + 1;
  localparam int A_PCON = NPORTS + 2;
  localparam int A_GEN = NPORTS + 3;
  localparam logic [PW-1:0] LAST = PW'(CLKS_PER_MC - 1);
  localparam logic [PW-1:0] SLOT = PW'(SAMPLE_SLOT);
  localparam logic [HW-1:0] HOLD = HW'(HOLD_SAMPLES);
  localparam logic [DW-1:0] KEEP_MASK = DW'(1) << PCON_KEEP;

  logic [1:0]    sync = '0;
  logic [PW-1:0] phase = '0;
  logic [HW-1:0] hi_cnt = '0;
  logic          rst_q = 1'b0;
  logic          sample;
  logic          wr_ok;

  assign sample  = (phase == SLOT);
  assign sys_rst = rst_q;
  assign wr_ok   = wr_en && !rst_q;

  always_ff @(posedge clk) begin
    sync  <= {sync[0], rst_pin};
    phase <= (phase == LAST) ? '0 : phase + 1'b1;
    if (sample) begin
      if (sync[1]) begin
        if (hi_cnt != HOLD) hi_cnt <= hi_cnt + 1'b1;
        if (hi_cnt >= HOLD - 1'b1) rst_q <= 1'b1;
      end else begin
        hi_cnt <= '0;
        rst_q  <= 1'b0;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NPORTS; g++) begin : g_port
      logic [DW-1:0] r;
      always_ff @(posedge clk) begin
        if (rst_q) r <= '1;
        else if (wr_ok && wr_addr == AW'(g)) r <= wr_data;
      end
      assign port_q[g*DW +: DW] = r;
    end
    for (g = 0; g < NGEN; g++) begin : g_gen
      logic [DW-1:0] r;
      always_ff @(posedge clk) begin
        if (rst_q) r <= '0;
        else if (wr_ok && wr_addr == AW'(A_GEN + g)) r <= wr_data;
      end
      assign gen_q[g*DW +: DW] = r;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst_q) begin
      sp_q   <= DW'(SP_INIT);
      pcon_q <= pcon_q & KEEP_MASK;
    end else if (wr_ok) begin
      if (wr_addr == AW'(A_SP))   sp_q   <= wr_data;
      if (wr_addr == AW'(A_PCON)) pcon_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok && wr_addr == AW'(A_SBUF)) sbuf_q <= wr_data;
  end
endmodule

// File: rtl/mc_reset_gate_chk.sv
module mc_reset_gate_chk #(
  parameter int PW         = 4,
  parameter int SAMPLE_SLOT = 9,
  parameter int NPORTS     = 4,
  parameter int NGEN       = 4,
  parameter int DW         = 8,
  parameter int PCON_KEEP  = 4,
  parameter int SP_INIT    = 7
) (
  input logic                 clk,
  input logic [PW-1:0]        phase,
  input logic                 sys_rst,
  input logic [NPORTS*DW-1:0] port_q,
  input logic [DW-1:0]        sp_q,
  input logic [DW-1:0]        sbuf_q,
  input logic [DW-1:0]        pcon_q,
  input logic [NGEN*DW-1:0]   gen_q
);
  logic [1:0] age = '0;
  always_ff @(posedge clk) if (age != 2'd3) age <= age + 1'b1;
  wire live = (age >= 2'd2);

  AST_RST_ON_SLOT: assert property (@(posedge clk) disable iff (!live)
    (sys_rst != $past(sys_rst)) |-> ($past(phase) == PW'(SAMPLE_SLOT))); // R1
  AST_PORTS_HIGH: assert property (@(posedge clk) disable iff (!live)
    sys_rst |=> (port_q == '1)); // R5
  AST_SP_INIT: assert property (@(posedge clk) disable iff (!live)
    sys_rst |=> (sp_q == DW'(SP_INIT))); // R6
  AST_GEN_CLEAR: assert property (@(posedge clk) disable iff (!live)
    sys_rst |=> (gen_q == '0)); // R7
  AST_SBUF_KEEP: assert property (@(posedge clk) disable iff (!live)
    sys_rst |=> $stable(sbuf_q)); // R8
  AST_PCON_KEEP: assert property (@(posedge clk) disable iff (!live)
    sys_rst |=> ($stable(pcon_q[PCON_KEEP]) && ((pcon_q & ~(DW'(1) << PCON_KEEP)) == '0))); // R9
endmodule

bind mc_reset_gate mc_reset_gate_chk #(
  .PW(PW), .SAMPLE_SLOT(SAMPLE_SLOT), .NPORTS(NPORTS), .NGEN(NGEN),
  .DW(DW), .PCON_KEEP(PCON_KEEP), .SP_INIT(SP_INIT)
) u_chk (
  .clk(clk), .phase(phase), .sys_rst(sys_rst), .port_q(port_q),
  .sp_q(sp_q), .sbuf_q(sbuf_q), .pcon_q(pcon_q), .gen_q(gen_q)
);

// File: tb/sim_mc_reset_gate.sv
`timescale 1ns/1ps
module sim_mc_reset_gate;
  logic clk = 1'b0;
  logic rst_pin = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic sys_rst;
  logic [31:0] port_q, gen_q;
  logic [7:0] sp_q, sbuf_q, pcon_q;

  int n_run = 0, n_fail = 0;
  int cyc = 0, rise_c = -1, fall_c = -1, pin_low_c = 0;
  logic prev_rst = 1'b0;
  logic saw_rise = 1'b0;

  always #10 clk = ~clk;

  mc_reset_gate u0 (.clk(clk), .rst_pin(rst_pin), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sys_rst(sys_rst), .port_q(port_q), .sp_q(sp_q),
    .sbuf_q(sbuf_q), .pcon_q(pcon_q), .gen_q(gen_q));

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (sys_rst === 1'b1 && prev_rst === 1'b0) begin rise_c = cyc; saw_rise = 1'b1; end
    if (sys_rst === 1'b0 && prev_rst === 1'b1) fall_c = cyc;
    prev_rst = sys_rst;
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input int n);
    @(negedge clk); rst_pin = 1'b1;
    idle(n);
    rst_pin = 1'b0; pin_low_c = cyc;
  endtask

  task automatic t_powerup();
    @(negedge clk); rst_pin = 1'b1;
    idle(36);
    check("R2 rst asserted", sys_rst, 1);
    check("R5 ports", port_q, 32'hFFFF_FFFF);
    check("R6 sp", sp_q, 8'h07);
    check("R7 gen", gen_q, 0);
    check("R7 pcon low bits", pcon_q & 8'hEF, 0);
    rst_pin = 1'b0; pin_low_c = cyc;
    idle(30);
    check("R4 rst released", sys_rst, 0);
    check("R4 release latency", (fall_c - pin_low_c) <= 14, 1);
    check("R1 edge spacing", (fall_c - rise_c) % 12, 0);
  endtask

  task automatic t_writes();
    wr(4'd0, 8'h12); wr(4'd3, 8'h34); wr(4'd4, 8'h33);
    wr(4'd5, 8'hA5); wr(4'd6, 8'hFF); wr(4'd7, 8'h5A); wr(4'd10, 8'hC3);
    idle(1);
    check("R10 port0", port_q[7:0], 8'h12);
    check("R10 port3", port_q[31:24], 8'h34);
    check("R10 sp", sp_q, 8'h33);
    check("R10 sbuf", sbuf_q, 8'hA5);
    check("R10 pcon", pcon_q, 8'hFF);
    check("R10 gen", gen_q, 32'hC300_005A);
  endtask

  task automatic t_glitch();
    saw_rise = 1'b0;
    pulse(12);
    idle(40);
    check("R3 no rst", saw_rise, 0);
    check("R3 sp kept", sp_q, 8'h33);
    check("R3 port kept", port_q[7:0], 8'h12);
    check("R3 gen kept", gen_q, 32'hC300_005A);
  endtask

  task automatic t_keep();
    saw_rise = 1'b0;
    pulse(24);
    idle(30);
    check("R2 two samples", saw_rise, 1);
    check("R1 edge spacing", (fall_c - rise_c) % 12, 0);
    check("R4 release", sys_rst, 0);
    check("R8 sbuf", sbuf_q, 8'hA5);
    check("R9 pcon", pcon_q, 8'h10);
    check("R6 sp", sp_q, 8'h07);
    check("R5 ports", port_q, 32'hFFFF_FFFF);
    check("R7 gen", gen_q, 0);
  endtask

  task automatic t_collide();
    wr(4'd6, 8'h00);
    @(negedge clk); wr_en = 1'b1; wr_addr = 4'd4; wr_data = 8'h44; rst_pin = 1'b1;
    idle(40);
    check("R10 write blocked", sp_q, 8'h07);
    check("R9 cleared bit stays", pcon_q, 8'h00);
    wr_en = 1'b0;
    idle(2);
    rst_pin = 1'b0;
    idle(30);
    check("R4 release", sys_rst, 0);
    wr(4'd4, 8'h44);
    idle(1);
    check("R10 write after", sp_q, 8'h44);
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    check("R4 idle", sys_rst, 0);
    t_powerup();
    t_writes();
    t_glitch();
    t_keep();
    t_collide();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule